// File: doc/BRIEF.md
# Byte Access Sequencer over Word Memory

This block gives a requester byte-granular loads and stores on top of a synchronous memory that can only read or write whole words. A word sits at each memory address, and the next word sits at the next address. Each request carries a byte address, a direction flag, a size flag and the data. The block splits the byte address into a word address and a lane number, then fetches the word that holds the byte.

A byte load picks the addressed lane out of the fetched word. A byte store has no byte enables to work with, so it runs as a sequence: fetch the word, clear the target lane with a mask, OR the shifted new byte into it, and write the whole word back. Word-sized loads and stores ignore the lane bits and move the complete word. The word width (16 or 32 bits) and the number of words are parameters.

Only one request is handled at a time. While one is in flight the block reports itself busy and drops any further request.

Top module: `byte_rmw_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `rd_byte` and `rd_word` are all zero.
- R2: A byte address `a` selects word `a >> log2(WORD_W/8)` and lane `a mod (WORD_W/8)`. Lane 0 is bits [7:0] and lane k is bits [8k+7:8k].
- R3: A byte load raises `done` on the second rising edge after the accepting edge. `rd_byte` then holds the addressed lane and `rd_word` holds the whole containing word.
- R4: A byte store writes the new byte into its lane and leaves every other lane of that word unchanged.
- R5: A byte store runs through fetch, merge, write-back and finish, and raises `done` on the fourth rising edge after the accepting edge.
- R6: Word accesses (`req_word`=1) ignore the lane bits of the address. A word store raises `done` on the second edge and stores `req_wword`. A word load raises `done` on the second edge and returns the full word on `rd_word`.
- R7: `busy` rises on the edge that accepts a request. It stays high until the edge that raises `done`, and it falls on that same edge.
- R8: A request presented while `busy` is high is dropped. It changes no memory word and does not delay the request in flight.
- R9: `done` is high for exactly one cycle per request. `rd_byte` and `rd_word` change only when a load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = whole-word access, 0 = byte access |
| req_addr | input | WORD_ADDR_W+log2(WORD_W/8) | Byte address |
| req_byte | input | 8 | Byte to store |
| req_wword | input | WORD_W | Word to store |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Byte returned by the last load |
| rd_word | output | WORD_W | Containing word returned by the last load |

## Verification
Loads and word stores must finish exactly two edges after the accepting edge, and byte stores exactly four edges after it. The bench counts rising edges from acceptance, samples `done` at each falling edge, and compares that count against the expected latency. Load data is compared only at the falling edge where `done` is first seen. After every byte store, the bench reads the whole word back and compares all lanes against a shadow model, so a store that disturbs a neighbouring lane is caught as soon as it happens.

// File: rtl/byte_rmw_pkg.sv
package byte_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_MERGE = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } rmw_state_e;
endpackage

// File: rtl/word_ram.sv
module word_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/byte_lane_shifter.sv
module byte_lane_shifter #(
  parameter int WORD_W = 32,
  localparam int BYTES = WORD_W / 8,
  localparam int OFS_W = $clog2(BYTES)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [7:0]        new_byte,
  output logic [7:0]        byte_out,
  output logic [WORD_W-1:0] word_merged
);
  localparam int SH_W = OFS_W + 3;

  logic [SH_W-1:0]   sh;
  logic [WORD_W-1:0] lane_mask;
  logic [WORD_W-1:0] placed;
  logic [7:0]        lanes [BYTES];

  assign sh = {ofs, 3'b000};

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign lanes[i] = word_in[8*i +: 8];
  end

  assign byte_out    = lanes[ofs];
  assign lane_mask   = {{(WORD_W-8){1'b0}}, 8'hFF} << sh;
  assign placed      = {{(WORD_W-8){1'b0}}, new_byte} << sh;
  assign word_merged = (word_in & ~lane_mask) | placed;
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import byte_rmw_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int WORD_ADDR_W = 6,
  localparam int OFS_W      = $clog2(WORD_W / 8),
  localparam int BYTE_ADDR_W = WORD_ADDR_W + OFS_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_word,
  input  logic [BYTE_ADDR_W-1:0] req_addr,
  input  logic [7:0]             req_byte,
  input  logic [WORD_W-1:0]      req_wword,
  input  logic [WORD_W-1:0]      ram_q,
  input  logic [7:0]             lane_byte,
  input  logic [WORD_W-1:0]      lane_merged,
  output logic [OFS_W-1:0]       cur_ofs,
  output logic [7:0]             cur_byte,
  output logic                   cur_word,
  output logic [WORD_ADDR_W-1:0] ram_addr,
  output logic                   ram_re,
  output logic                   ram_we,
  output logic [WORD_W-1:0]      ram_wdata,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             rd_byte,
  output logic [WORD_W-1:0]      rd_word
);
  rmw_state_e             state_q;
  logic [WORD_ADDR_W-1:0] waddr_q;
  logic [OFS_W-1:0]       ofs_q;
  logic                   is_wr_q;
  logic                   is_word_q;
  logic [7:0]             bdata_q;
  logic [WORD_W-1:0]      store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      waddr_q   <= '0;
      ofs_q     <= '0;
      is_wr_q   <= 1'b0;
      is_word_q <= 1'b0;
      bdata_q   <= '0;
      store_q   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_byte   <= '0;
      rd_word   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            waddr_q   <= req_addr[BYTE_ADDR_W-1:OFS_W];
            ofs_q     <= req_addr[OFS_W-1:0];
            is_wr_q   <= req_write;
            is_word_q <= req_word;
            bdata_q   <= req_byte;
            store_q   <= req_wword;
            busy      <= 1'b1;
            state_q   <= (req_write && req_word) ? ST_WRITE : ST_READ;
          end
        end
        ST_READ: begin
          state_q <= is_wr_q ? ST_MERGE : ST_DONE;
        end
        ST_MERGE: begin
          store_q <= lane_merged;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (!is_wr_q) begin
            rd_byte <= lane_byte;
            rd_word <= ram_q;
          end
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ram_addr  = waddr_q;
  assign ram_re    = (state_q == ST_READ);
  assign ram_we    = (state_q == ST_WRITE);
  assign ram_wdata = store_q;
  assign cur_ofs   = ofs_q;
  assign cur_byte  = bdata_q;
  assign cur_word  = is_word_q;
endmodule

// File: rtl/byte_rmw_unit.sv
module byte_rmw_unit #(
  parameter int WORD_W       = 32,
  parameter int WORD_ADDR_W  = 6,
  localparam int OFS_W       = $clog2(WORD_W / 8),
  localparam int BYTE_ADDR_W = WORD_ADDR_W + OFS_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_word,
  input  logic [BYTE_ADDR_W-1:0] req_addr,
  input  logic [7:0]             req_byte,
  input  logic [WORD_W-1:0]      req_wword,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             rd_byte,
  output logic [WORD_W-1:0]      rd_word
);
  logic [WORD_W-1:0]      ram_q;
  logic [WORD_W-1:0]      ram_wdata;
  logic [WORD_ADDR_W-1:0] ram_addr;
  logic                   ram_re;
  logic                   ram_we;
  logic [OFS_W-1:0]       cur_ofs;
  logic [7:0]             cur_byte;
  logic                   cur_word;
  logic [7:0]             lane_byte;
  logic [WORD_W-1:0]      lane_merged;

  rmw_ctrl #(
    .WORD_W      (WORD_W),
    .WORD_ADDR_W (WORD_ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_word    (req_word),
    .req_addr    (req_addr),
    .req_byte    (req_byte),
    .req_wword   (req_wword),
    .ram_q       (ram_q),
    .lane_byte   (lane_byte),
    .lane_merged (lane_merged),
    .cur_ofs     (cur_ofs),
    .cur_byte    (cur_byte),
    .cur_word    (cur_word),
    .ram_addr    (ram_addr),
    .ram_re      (ram_re),
    .ram_we      (ram_we),
    .ram_wdata   (ram_wdata),
    .busy        (busy),
    .done        (done),
    .rd_byte     (rd_byte),
    .rd_word     (rd_word)
  );

  byte_lane_shifter #(
    .WORD_W (WORD_W)
  ) u_lane (
    .word_in     (ram_q),
    .ofs         (cur_ofs),
    .new_byte    (cur_byte),
    .byte_out    (lane_byte),
    .word_merged (lane_merged)
  );

  word_ram #(
    .DATA_W (WORD_W),
    .ADDR_W (WORD_ADDR_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .q     (ram_q)
  );
endmodule

// File: rtl/byte_rmw_checker.sv
module byte_rmw_checker #(
  parameter int WORD_W = 32,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              ram_we,
  input logic              cur_word,
  input logic [OFS_W-1:0]  cur_ofs,
  input logic [7:0]        rd_byte,
  input logic [WORD_W-1:0] rd_word,
  input logic [WORD_W-1:0] ram_wdata,
  input logic [WORD_W-1:0] ram_q
);
  logic [WORD_W-1:0] keep_mask;
  assign keep_mask = ~({{(WORD_W-8){1'b0}}, 8'hFF} << {cur_ofs, 3'b000});

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done)); // R7
  AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> !(!busy && !done)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rd_byte) && $stable(rd_word))); // R9
  AST_KEEP_LANES: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !cur_word) |-> (((ram_wdata ^ ram_q) & keep_mask) == '0)); // R4
endmodule

bind byte_rmw_unit byte_rmw_checker #(
  .WORD_W (WORD_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .ram_we    (ram_we),
  .cur_word  (cur_word),
  .cur_ofs   (cur_ofs),
  .rd_byte   (rd_byte),
  .rd_word   (rd_word),
  .ram_wdata (ram_wdata),
  .ram_q     (ram_q)
);

// File: tb/sim_byte_rmw_unit.sv
module sim_byte_rmw_unit;
  localparam int WW    = 32;
  localparam int WAW   = 4;
  localparam int NW    = 1 << WAW;
  localparam int BA    = WAW + 2;
  localparam int NB    = NW * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_word = 1'b0;
  logic [BA-1:0] req_addr = '0;
  logic [7:0]    req_byte = '0;
  logic [WW-1:0] req_wword = '0;
  logic          busy, done;
  logic [7:0]    rd_byte;
  logic [WW-1:0] rd_word;

  int checks = 0;
  int fails  = 0;
  logic [WW-1:0] model [NW];

  always #4 clk = ~clk;

  byte_rmw_unit #(.WORD_W(WW), .WORD_ADDR_W(WAW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_byte(req_byte),
    .req_wword(req_wword), .busy(busy), .done(done),
    .rd_byte(rd_byte), .rd_word(rd_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Issue one request, return edges from acceptance to done.
  task automatic run_req(input logic wr, input logic wd, input logic [BA-1:0] a,
                         input logic [7:0] b, input logic [WW-1:0] w,
                         output int lat);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd;
    req_addr = a; req_byte = b; req_wword = w;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", WW'(busy), 1);
    n = 0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(busy == 1'b0, "R7 busy low with done", WW'(busy), 0);
    lat = n;
  endtask

  function automatic logic [WW-1:0] pat(input int w);
    return WW'((w + 1) * 32'h9E3779B9);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    checks++; fails++;
    summary();
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] nb;
    logic [7:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
    chk(rd_byte == 0 && rd_word == 0, "R1 reset data", rd_word, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && rd_word == 0, "R1 after reset", rd_word, 0);

    // R6: word stores, with nonzero lane bits in the address
    for (int w = 0; w < NW; w++) begin
      run_req(1'b1, 1'b1, BA'(w * 4 + (w % 4)), 8'h00, pat(w), lat);
      model[w] = pat(w);
      chk(lat == 2, "R6 word store latency", lat, 2);
    end
    // R6: word loads, lane bits ignored
    for (int w = 0; w < NW; w++) begin
      run_req(1'b0, 1'b1, BA'(w * 4 + 3 - (w % 4)), 8'h00, '0, lat);
      chk(lat == 2, "R6 word load latency", lat, 2);
      chk(rd_word == model[w], "R6 word load data", rd_word, model[w]);
    end
    // R2 R3: byte loads over every byte address
    for (int a = 0; a < NB; a++) begin
      run_req(1'b0, 1'b0, BA'(a), 8'h00, '0, lat);
      chk(lat == 2, "R3 byte load latency", lat, 2);
      chk(rd_byte == model[a / 4][8 * (a % 4) +: 8], "R2 lane select",
          rd_byte, model[a / 4][8 * (a % 4) +: 8]);
      chk(rd_word == model[a / 4], "R3 containing word", rd_word, model[a / 4]);
    end
    // R4 R5: byte stores over every byte address, full word read back
    for (int a = 0; a < NB; a++) begin
      nb = 8'(a * 7 + 8'h5A);
      held = rd_byte;
      run_req(1'b1, 1'b0, BA'(a), nb, '0, lat);
      model[a / 4][8 * (a % 4) +: 8] = nb;
      chk(lat == 4, "R5 byte store latency", lat, 4);
      chk(rd_byte == held, "R9 rd_byte held over store", rd_byte, held);
      run_req(1'b0, 1'b1, BA'((a / 4) * 4), 8'h00, '0, lat);
      chk(rd_word == model[a / 4], "R4 word after byte store", rd_word, model[a / 4]);
    end
    // R8: request while busy is dropped
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = 1'b0;
    req_addr = BA'(5); req_byte = 8'hC3; req_wword = '0;
    @(negedge clk);
    req_write = 1'b1; req_word = 1'b1; req_addr = BA'(7 * 4); req_wword = 32'hDEAD_BEEF;
    lat = 0;
    @(negedge clk); lat++;
    @(negedge clk); lat++;
    req_valid = 1'b0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    model[1][15:8] = 8'hC3;
    chk(lat == 4, "R8 in-flight latency kept", lat, 4);
    run_req(1'b0, 1'b1, BA'(7 * 4), 8'h00, '0, lat);
    chk(rd_word == model[7], "R8 dropped store no effect", rd_word, model[7]);
    run_req(1'b0, 1'b1, BA'(4), 8'h00, '0, lat);
    chk(rd_word == model[1], "R8 accepted store landed", rd_word, model[1]);
    // R9: done lasts one cycle
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", WW'(done), 0);

    summary();
    $finish;
  end
endmodule